// File: doc/BRIEF.md
# Shared Interrupt Flag and Mask Controller

This block merges two external interrupt sources, A and B, onto one shared request bit that a processor core can take. Each source has its own mask bit and its own sticky flag in a configuration register. The shared pending bit sits in a flag register. An enable bit in a separate mask register and a global disable input gate that pending bit into an acknowledge-eligible request. A third pin, C, gets edge detection only. A configuration bit selects whether C reacts to both edges or to falling edges only. Every pin passes through a two-flop synchronizer before any edge is judged.

Software uses a simple write-strobe bus with a combinational read port. When the request is taken, the service routine reads the per-source flags to find which source fired. It then clears each flag by writing 1 to it. Clearing a source flag leaves the shared pending bit alone. The pending bit is cleared by writing 1 to it, or by the core's acknowledge strobe.

Register map. A write applies at the clock edge where `wrEn` is high.
- Address 0, configuration register:
  - bit 0 = source A mask, where 1 means enabled.
  - bit 1 = source B mask.
  - bit 2 = source A flag, write-1-to-clear.
  - bit 3 = source B flag, write-1-to-clear.
  - bit 4 = pin C edge mode.
- Address 1, flag register: bit 0 = shared pending bit, write-1-to-clear.
- Address 2, mask register: bit 0 = shared enable.
- All other bits and address 3 read as 0.

Top module: `shirq_top`

## Requirements
- R1: After reset every register bit is 0: both sources masked, both flags clear, edge mode 0, pending 0, enable 0. Reads of addresses 0, 1 and 2 return 0 and `irqReq` is 0.
- R2: A source event is a falling edge of the synchronized input. With that source's mask bit at 1, the event sets the source's flag and the pending bit at the third rising clock edge after the pin changes.
- R3: While a source's mask bit is 0, its falling edges set neither its flag nor the pending bit, whatever the enable bit holds. Rising edges of sources A and B never set anything.
- R4: The pending bit is set by an unmasked event even when the enable bit is 0. `irqReq` is 1 exactly when pending is 1, enable is 1 and `intDisable` is 0.
- R5: Writing 1 to a source flag bit at address 0 clears that flag and leaves the pending bit unchanged. Writing 0 to a flag bit has no effect on it.
- R6: The pending bit is cleared by writing 1 to bit 0 of address 1, or by `ackIn` high for one cycle. Writing 0 to it has no effect. `ackIn` does not clear either source flag.
- R7: When a set and a clear of the pending bit, or of a source flag, fall in the same cycle, the set wins.
- R8: `pinCEdge` pulses high for one cycle at the third rising clock edge after pin C changes. With edge mode 0 the pulse follows both edges of C. With edge mode 1 it follows falling edges only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcAIn | input | 1 | Source A pin, asynchronous, idles high |
| srcBIn | input | 1 | Source B pin, asynchronous, idles high |
| pinCIn | input | 1 | Pin C, asynchronous, idles high |
| intDisable | input | 1 | Global interrupt disable, 1 blocks the request |
| ackIn | input | 1 | Core acknowledge strobe, clears the pending bit |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data of the addressed register |
| irqReq | output | 1 | Acknowledge-eligible interrupt request |
| pinCEdge | output | 1 | One-cycle pulse on a qualifying pin C edge |

## Verification
The bench pulses a source while its mask is 0 and then reads every register. A design that let the enable bit, rather than the source mask, gate flag setting would show a stray flag or pending bit there. It clears source flags while the shared pending bit is set and checks that pending stays 1; a design that tied the two together would drop the request early. It also checks that an acknowledge leaves the flags set. The bench times an acknowledge, and separately a flag-clear write, to land in the very cycle a new event is registered. A design that let the clear win would lose that interrupt. Finally it toggles pin C in both edge modes, where a wrong edge select shows up as an extra or missing pulse on the rising edge.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int NUM_LINES = 3;
  localparam int LINE_A = 0;
  localparam int LINE_B = 1;
  localparam int LINE_C = 2;
  localparam int CFG_W = 5;

  localparam int ADDR_CFG = 0;
  localparam int ADDR_FLAG = 1;
  localparam int ADDR_MASK = 2;

  localparam int BIT_MASK_A = 0;
  localparam int BIT_MASK_B = 1;
  localparam int BIT_FLAG_A = 2;
  localparam int BIT_FLAG_B = 3;
  localparam int BIT_MODE = 4;
  localparam int BIT_SHARED = 0;

  typedef struct packed {
    logic setA;
    logic setB;
    logic clrFlagA;
    logic clrFlagB;
    logic setPend;
    logic clrPend;
    logic wrCfg;
    logic wrEnable;
    logic edgeHit;
  } strobe_t;
endpackage

// File: rtl/shirq_sync.sv
module shirq_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic syncOut,
  output logic prevOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
      prevOut <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prevOut <= chain[STAGES-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/shirq_ctl.sv
module shirq_ctl
  import shirq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 ackIn,
  input  logic [NUM_LINES-1:0] syncLvl,
  input  logic [NUM_LINES-1:0] prevLvl,
  input  logic                 maskA,
  input  logic                 maskB,
  input  logic                 edgeMode,
  output strobe_t              strb
);
  logic [NUM_LINES-1:0] fallVec;
  logic [NUM_LINES-1:0] anyVec;
  logic selCfg, selFlag, selMask;

  assign fallVec = prevLvl & ~syncLvl;
  assign anyVec  = prevLvl ^ syncLvl;

  assign selCfg  = wrEn && (addr == ADDR_W'(ADDR_CFG));
  assign selFlag = wrEn && (addr == ADDR_W'(ADDR_FLAG));
  assign selMask = wrEn && (addr == ADDR_W'(ADDR_MASK));

  always_comb begin
    strb = '0;
    strb.setA     = fallVec[LINE_A] & maskA;
    strb.setB     = fallVec[LINE_B] & maskB;
    strb.setPend  = strb.setA | strb.setB;
    strb.clrFlagA = selCfg & cfgData[BIT_FLAG_A];
    strb.clrFlagB = selCfg & cfgData[BIT_FLAG_B];
    strb.clrPend  = (selFlag & cfgData[BIT_SHARED]) | ackIn;
    strb.wrCfg    = selCfg;
    strb.wrEnable = selMask;
    strb.edgeHit  = edgeMode ? fallVec[LINE_C] : anyVec[LINE_C];
  end
endmodule

// File: rtl/shirq_dp.sv
module shirq_dp
  import shirq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              intDisable,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq,
  output logic              pinCEdge,
  output logic              maskA,
  output logic              maskB,
  output logic              flagA,
  output logic              flagB,
  output logic              edgeMode,
  output logic              pend,
  output logic              enable
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskA    <= 1'b0;
      maskB    <= 1'b0;
      edgeMode <= 1'b0;
      enable   <= 1'b0;
      pinCEdge <= 1'b0;
    end else begin
      if (strb.wrCfg) begin
        maskA    <= cfgData[BIT_MASK_A];
        maskB    <= cfgData[BIT_MASK_B];
        edgeMode <= cfgData[BIT_MODE];
      end
      if (strb.wrEnable) enable <= cfgData[BIT_SHARED];
      pinCEdge <= strb.edgeHit;
    end
  end

  // sticky bits: a set in the same cycle overrides any clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagB <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (strb.setA) flagA <= 1'b1;
      else if (strb.clrFlagA) flagA <= 1'b0;
      if (strb.setB) flagB <= 1'b1;
      else if (strb.clrFlagB) flagB <= 1'b0;
      if (strb.setPend) pend <= 1'b1;
      else if (strb.clrPend) pend <= 1'b0;
    end
  end

  assign irqReq = pend & enable & ~intDisable;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(ADDR_CFG): begin
        rdData[BIT_MASK_A] = maskA;
        rdData[BIT_MASK_B] = maskB;
        rdData[BIT_FLAG_A] = flagA;
        rdData[BIT_FLAG_B] = flagB;
        rdData[BIT_MODE]   = edgeMode;
      end
      ADDR_W'(ADDR_FLAG): rdData[BIT_SHARED] = pend;
      ADDR_W'(ADDR_MASK): rdData[BIT_SHARED] = enable;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/shirq_top.sv
module shirq_top
  import shirq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcAIn,
  input  logic              srcBIn,
  input  logic              pinCIn,
  input  logic              intDisable,
  input  logic              ackIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq,
  output logic              pinCEdge
);
  logic [NUM_LINES-1:0] pinVec, syncLvl, prevLvl;
  logic [CFG_W-1:0] cfgData;
  logic unusedWrHigh;
  strobe_t strb;
  logic maskA, maskB, flagA, flagB, edgeMode, pend, enable;

  assign pinVec = {pinCIn, srcBIn, srcAIn};
  assign cfgData = wrData[CFG_W-1:0];
  assign unusedWrHigh = ^wrData[DATA_W-1:CFG_W];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
    shirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rstN(rstN), .din(pinVec[i]),
      .syncOut(syncLvl[i]), .prevOut(prevLvl[i])
    );
  end

  shirq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .wrEn(wrEn), .addr(addr), .cfgData(cfgData), .ackIn(ackIn),
    .syncLvl(syncLvl), .prevLvl(prevLvl),
    .maskA(maskA), .maskB(maskB), .edgeMode(edgeMode), .strb(strb)
  );

  shirq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgData(cfgData), .addr(addr),
    .intDisable(intDisable), .rdData(rdData), .irqReq(irqReq),
    .pinCEdge(pinCEdge), .maskA(maskA), .maskB(maskB), .flagA(flagA),
    .flagB(flagB), .edgeMode(edgeMode), .pend(pend), .enable(enable)
  );
endmodule

// File: rtl/shirq_chk.sv
module shirq_chk
  import shirq_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    ackIn,
  input logic    intDisable,
  input logic    irqReq,
  input logic    maskA,
  input logic    maskB,
  input logic    flagA,
  input logic    flagB,
  input logic    pend,
  input strobe_t strb
);
  // R3
  flag_a_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagA) |-> $past(maskA));
  // R3
  flag_b_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagB) |-> $past(maskB));
  // R3
  pend_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend) |-> $past(maskA || maskB));
  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (!intDisable && pend));
  // R5
  flag_clear_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlagA || strb.clrFlagB) && pend && !strb.clrPend |=> pend);
  // R6
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackIn && !strb.setPend |=> !pend);
  // R6
  ack_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackIn && flagA && !strb.clrFlagA |=> flagA);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setPend |=> pend);
endmodule

bind shirq_top shirq_chk u_chk (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .intDisable(intDisable),
  .irqReq(irqReq), .maskA(maskA), .maskB(maskB), .flagA(flagA),
  .flagB(flagB), .pend(pend), .strb(strb)
);

// File: tb/shirq_top_bench.sv
`timescale 1ns/1ps
module shirq_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcAIn = 1'b1, srcBIn = 1'b1, pinCIn = 1'b1;
  logic intDisable = 1'b0, ackIn = 1'b0, wrEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqReq, pinCEdge;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  shirq_top u_shirq_top (
    .clk(clk), .rstN(rstN), .srcAIn(srcAIn), .srcBIn(srcBIn), .pinCIn(pinCIn),
    .intDisable(intDisable), .ackIn(ackIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqReq(irqReq), .pinCEdge(pinCEdge)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input int exp);
    addr = a;
    #1;
    chk(req, int'(rdData), exp);
  endtask

  task automatic t_reset();
    rdChk("R1 cfg", 2'd0, 0);
    rdChk("R1 flag", 2'd1, 0);
    rdChk("R1 mask", 2'd2, 0);
    chk("R1 irqReq", int'(irqReq), 0);
  endtask

  task automatic t_masked();
    @(negedge clk); srcAIn = 1'b0; srcBIn = 1'b0;
    waitN(4);
    srcAIn = 1'b1; srcBIn = 1'b1;
    waitN(4);
    rdChk("R3 masked cfg", 2'd0, 0);
    rdChk("R3 masked pend", 2'd1, 0);
  endtask

  task automatic t_unmasked();
    wr(2'd0, 8'h03);
    @(negedge clk); srcAIn = 1'b0;
    waitN(2);
    rdChk("R2 flag not yet", 2'd0, 8'h03);
    waitN(1);
    rdChk("R2 flagA set", 2'd0, 8'h07);
    rdChk("R2 pend set", 2'd1, 1);
    chk("R4 irq off with enable 0", int'(irqReq), 0);
    srcAIn = 1'b1;
    waitN(4);
    rdChk("R3 rising edge ignored", 2'd0, 8'h07);
  endtask

  task automatic t_gate();
    wr(2'd2, 8'h01);
    chk("R4 irq on", int'(irqReq), 1);
    intDisable = 1'b1; #1;
    chk("R4 global disable", int'(irqReq), 0);
    intDisable = 1'b0; #1;
    chk("R4 irq back", int'(irqReq), 1);
  endtask

  task automatic t_w1c();
    wr(2'd0, 8'h07);
    rdChk("R5 flagA cleared", 2'd0, 8'h03);
    rdChk("R5 pend kept", 2'd1, 1);
    @(negedge clk); srcBIn = 1'b0;
    waitN(3);
    srcBIn = 1'b1;
    rdChk("R2 flagB set", 2'd0, 8'h0B);
    wr(2'd0, 8'h03);
    rdChk("R5 write 0 keeps flagB", 2'd0, 8'h0B);
    waitN(3);
  endtask

  task automatic t_clear();
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
    rdChk("R6 ack clears pend", 2'd1, 0);
    chk("R6 irq off after ack", int'(irqReq), 0);
    rdChk("R6 ack keeps flags", 2'd0, 8'h0B);
    @(negedge clk); srcAIn = 1'b0;
    waitN(3);
    srcAIn = 1'b1;
    rdChk("R2 pend again", 2'd1, 1);
    wr(2'd1, 8'h00);
    rdChk("R6 write 0 keeps pend", 2'd1, 1);
    wr(2'd1, 8'h01);
    rdChk("R6 write 1 clears pend", 2'd1, 0);
    wr(2'd0, 8'h0F);
    rdChk("R5 both flags cleared", 2'd0, 8'h03);
    waitN(3);
  endtask

  task automatic t_priority();
    @(negedge clk); srcBIn = 1'b0;
    waitN(2);
    ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
    rdChk("R7 set beats ack", 2'd1, 1);
    srcBIn = 1'b1;
    waitN(4);
    @(negedge clk); srcBIn = 1'b0;
    waitN(2);
    wrEn = 1'b1; addr = 2'd0; wrData = 8'h0B;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    rdChk("R7 set beats flag clear", 2'd0, 8'h0B);
    srcBIn = 1'b1;
    waitN(4);
  endtask

  task automatic t_edges();
    @(negedge clk); pinCIn = 1'b0;
    waitN(2);
    chk("R8 no early pulse", int'(pinCEdge), 0);
    waitN(1);
    chk("R8 mode0 fall pulse", int'(pinCEdge), 1);
    waitN(1);
    chk("R8 pulse one cycle", int'(pinCEdge), 0);
    pinCIn = 1'b1;
    waitN(3);
    chk("R8 mode0 rise pulse", int'(pinCEdge), 1);
    wr(2'd0, 8'h13);
    rdChk("R8 mode bit", 2'd0, 8'h1B);
    @(negedge clk); pinCIn = 1'b0;
    waitN(3);
    chk("R8 mode1 fall pulse", int'(pinCEdge), 1);
    pinCIn = 1'b1;
    waitN(3);
    chk("R8 mode1 rise ignored", int'(pinCEdge), 0);
    waitN(1);
    chk("R8 mode1 rise ignored later", int'(pinCEdge), 0);
  endtask

  task automatic t_mask_with_enable();
    wr(2'd0, 8'h19);
    wr(2'd1, 8'h01);
    @(negedge clk); srcBIn = 1'b0;
    waitN(4);
    srcBIn = 1'b1;
    rdChk("R3 masked B with enable", 2'd1, 0);
    rdChk("R3 flagB stays clear", 2'd0, 8'h11);
    chk("R3 no request", int'(irqReq), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_masked();
    t_unmasked();
    t_gate();
    t_w1c();
    t_clear();
    t_priority();
    t_edges();
    t_mask_with_enable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule